// File: doc/BRIEF.md
# DDR2 Command Decoder and Bank Tracker

This block watches a DDR2-style command bus on the memory side. It samples chip select, the three command strobes, the bank address and the address bus on every rising clock edge. It turns these into one of seven operations: no-operation, activate, read, write, precharge, refresh or mode-register load. It keeps the open or closed state and the open row of each of eight banks. It holds four mode registers. Any command that the current bank state does not allow raises a one-cycle error pulse.

A column command can ask for auto-precharge through address bit 10. The bank then closes by itself once the burst ends. The burst length comes from the low three bits of mode register 0. The block only checks whether commands are legal. It has no data path, no timing checks between commands, no refresh counter and no power-down handling.

Top module: `ddr2_cmd_tracker`

## Requirements
- R1: The registered command output shows the operation sampled at the previous rising edge. The codes are 0 no-operation, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh and 6 mode load. The strobes {ras_n,cas_n,we_n} map as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load, and 111 or 110 no-operation. When cs_n is sampled high, the command is a no-operation and changes no state.
- R2: An activate to a closed bank opens that bank. The bank's row output, bits [b*14 +: 14] of open_rows_o, then holds the address, and no other bank changes.
- R3: A read or write to a closed bank gives err_o high for exactly the following cycle and changes no bank state.
- R4: An activate to a bank that is already open gives an error pulse and leaves its recorded row unchanged.
- R5: A precharge with address bit 10 low closes only the bank named by ba.
- R6: A precharge with address bit 10 high closes every bank, whatever ba holds.
- R7: A mode load while all banks are closed writes the address into mode register ba[1:0], which is bits [k*14 +: 14] of mode_regs_o.
- R8: A refresh or mode load while any bank is open gives an error pulse and leaves every mode register unchanged.
- R9: A read or write with address bit 10 high closes its bank BL/2 edges after the command edge. BL is 4 when mode register 0 bits [2:0] equal 3'b010 and 8 for every other value. The bank stays open until then.
- R10: During reset all banks are closed, all rows and mode registers are zero, err_o is low and the command output is no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| ba | input | 3 | Bank address |
| addr | input | 14 | Row, column or opcode; bit 10 is the precharge qualifier |
| cmd_o | output | 3 | Registered decoded command |
| err_o | output | 1 | One-cycle pulse for an illegal command |
| bank_open_o | output | 8 | Open flag per bank |
| open_rows_o | output | 112 | Row recorded for each bank |
| mode_regs_o | output | 56 | Four mode registers |

## Verification
The hardest situation to reach is an auto-precharge countdown that is still running. The bank looks open, yet it will close a fixed number of edges later, and the exact edge depends on a mode register field. The stimulus first loads mode register 0 with each burst setting while all banks are closed. It then opens a bank and issues a column command with bit 10 set. It samples the open flag after every idle edge, so that the closing edge is pinned to the cycle. The error cases are reached by building a specific open-bank pattern first and then issuing the offending command against it.

// File: rtl/ddr2_cmd_pkg.sv
// Shared types for the DDR2 command tracker.
// Assumes the burst-length field uses 3'b010 for four beats; any other value means eight.
package ddr2_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_LMR = 3'd6
    } cmd_e;

    localparam logic [2:0] BL_FIELD_FOUR = 3'b010;

    // Number of clock edges a burst occupies for a given length field
    function automatic logic [2:0] burst_edges(input logic [2:0] bl_field);
        return (bl_field == BL_FIELD_FOUR) ? 3'd2 : 3'd4;
    endfunction

endpackage

// File: rtl/ddr2_cmd_decode.sv
// Combinational command decoder.
// Maps the chip-select and strobe levels to an operation code.
// Assumes the inputs are stable around the rising edge; a deselected chip is always a no-operation.
module ddr2_cmd_decode
    import ddr2_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Translate the strobe pattern into an operation
    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_LMR;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddr2_bank_slot.sv
// State of one bank: open flag, open row, and the auto-precharge countdown.
// Assumes the parent only raises act_i for a closed bank and col_i for an open bank.
// close_i has priority over every other request.
module ddr2_bank_slot #(
    parameter int ROW_W = 14,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             col_i,
    input  logic             ap_i,
    input  logic             close_i,
    input  logic [CNT_W-1:0] burst_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);

    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;

    // Track open state, row and the self-timed close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (close_i) begin
            open_o <= 1'b0;
            pend_q <= 1'b0;
        end else if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
        end else if (col_i && ap_i) begin
            pend_q <= 1'b1;
            cnt_q  <= burst_i;
        end else if (pend_q) begin
            if (cnt_q == CNT_W'(1)) begin
                open_o <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/ddr2_mode_regs.sv
// Bank of mode registers written by a mode-load command.
// Assumes the parent raises wr_i only when the load is legal.
module ddr2_mode_regs #(
    parameter int DATA_W = 14,
    parameter int NUM_MR = 4,
    localparam int SEL_W = $clog2(NUM_MR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_i,
    input  logic [SEL_W-1:0]         sel_i,
    input  logic [DATA_W-1:0]        data_i,
    output logic [NUM_MR*DATA_W-1:0] regs_o
);

    for (genvar k = 0; k < NUM_MR; k++) begin : g_mr
        // Hold one mode register, loaded when selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_o[k*DATA_W +: DATA_W] <= '0;
            end else if (wr_i && (sel_i == SEL_W'(k))) begin
                regs_o[k*DATA_W +: DATA_W] <= data_i;
            end
        end
    end

endmodule

// File: rtl/ddr2_cmd_tracker.sv
// Top of the DDR2 command decoder and bank tracker.
// Decodes each sampled command, checks it against the bank state and applies it.
// Illegal commands raise err_o for one cycle and change nothing.
// Assumes one command per clock and a synchronous active-low reset.
module ddr2_cmd_tracker
    import ddr2_cmd_pkg::*;
#(
    parameter int BANK_W = 3,
    parameter int ADDR_W = 14,
    parameter int AP_BIT = 10,
    parameter int NUM_MR = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic [BANK_W-1:0]           ba,
    input  logic [ADDR_W-1:0]           addr,
    output logic [2:0]                  cmd_o,
    output logic                        err_o,
    output logic [(1<<BANK_W)-1:0]      bank_open_o,
    output logic [(1<<BANK_W)*ADDR_W-1:0] open_rows_o,
    output logic [NUM_MR*ADDR_W-1:0]    mode_regs_o
);

    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int SEL_W     = $clog2(NUM_MR);
    localparam int CNT_W     = 3;

    cmd_e             cmd_dec;
    logic             legal;
    logic             act_go;
    logic             col_go;
    logic             pre_go;
    logic             lmr_go;
    logic [CNT_W-1:0] burst_len;

    ddr2_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd_dec)
    );

    // Judge the command against the current bank state
    always_comb begin
        unique case (cmd_dec)
            CMD_ACT:         legal = !bank_open_o[ba];
            CMD_RD, CMD_WR:  legal = bank_open_o[ba];
            CMD_REF, CMD_LMR: legal = !(|bank_open_o);
            default:         legal = 1'b1;
        endcase
    end

    assign act_go    = (cmd_dec == CMD_ACT) && legal;
    assign col_go    = ((cmd_dec == CMD_RD) || (cmd_dec == CMD_WR)) && legal;
    assign pre_go    = (cmd_dec == CMD_PRE);
    assign lmr_go    = (cmd_dec == CMD_LMR) && legal;
    assign burst_len = burst_edges(mode_regs_o[2:0]);

    // Register the decoded command and the error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o <= CMD_NOP;
            err_o <= 1'b0;
        end else begin
            cmd_o <= cmd_dec;
            err_o <= !legal;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (ba == BANK_W'(b));

        ddr2_bank_slot #(
            .ROW_W (ADDR_W),
            .CNT_W (CNT_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_i   (act_go && hit),
            .row_i   (addr),
            .col_i   (col_go && hit),
            .ap_i    (addr[AP_BIT]),
            .close_i (pre_go && (addr[AP_BIT] || hit)),
            .burst_i (burst_len),
            .open_o  (bank_open_o[b]),
            .row_o   (open_rows_o[b*ADDR_W +: ADDR_W])
        );
    end

    ddr2_mode_regs #(
        .DATA_W (ADDR_W),
        .NUM_MR (NUM_MR)
    ) u_mr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (lmr_go),
        .sel_i  (ba[SEL_W-1:0]),
        .data_i (addr),
        .regs_o (mode_regs_o)
    );

endmodule

// File: rtl/ddr2_cmd_tracker_chk.sv
// Checker for ddr2_cmd_tracker, attached by bind.
// Relates the sampled bus to the registered outputs one edge later.
module ddr2_cmd_tracker_chk #(
    parameter int BANK_W = 3,
    parameter int ADDR_W = 14,
    parameter int AP_BIT = 10,
    parameter int NUM_MR = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          cs_n,
    input logic                          ras_n,
    input logic                          cas_n,
    input logic                          we_n,
    input logic [BANK_W-1:0]             ba,
    input logic [ADDR_W-1:0]             addr,
    input logic [2:0]                    cmd_o,
    input logic                          err_o,
    input logic [(1<<BANK_W)-1:0]        bank_open_o,
    input logic [(1<<BANK_W)*ADDR_W-1:0] open_rows_o,
    input logic [NUM_MR*ADDR_W-1:0]      mode_regs_o
);

    logic is_act, is_col, is_pre, is_ref_lmr;
    assign is_act     = !cs_n && !ras_n &&  cas_n &&  we_n;
    assign is_col     = !cs_n &&  ras_n && !cas_n;
    assign is_pre     = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_ref_lmr = !cs_n && !ras_n && !cas_n;

    p_deselect_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (cmd_o == 3'd0) && !err_o);

    p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && !bank_open_o[ba]) |=> bank_open_o[$past(ba)]);

    p_col_closed_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_col && !bank_open_o[ba]) |=> err_o);

    p_act_open_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act && bank_open_o[ba]) |=> err_o && $stable(open_rows_o));

    p_pre_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && addr[AP_BIT]) |=> (bank_open_o == '0));

    p_ref_lmr_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref_lmr && (|bank_open_o)) |=> err_o && $stable(mode_regs_o));

endmodule

bind ddr2_cmd_tracker ddr2_cmd_tracker_chk #(
    .BANK_W (BANK_W),
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT),
    .NUM_MR (NUM_MR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .ba          (ba),
    .addr        (addr),
    .cmd_o       (cmd_o),
    .err_o       (err_o),
    .bank_open_o (bank_open_o),
    .open_rows_o (open_rows_o),
    .mode_regs_o (mode_regs_o)
);

// File: tb/ddr2_cmd_tracker_tb_top.sv
// Directed bench for ddr2_cmd_tracker: one task per scenario.
module ddr2_cmd_tracker_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [2:0]   ba = '0;
    logic [13:0]  addr = '0;
    logic [2:0]   cmd_o;
    logic         err_o;
    logic [7:0]   bank_open_o;
    logic [111:0] open_rows_o;
    logic [55:0]  mode_regs_o;

    int total = 0;
    int bad   = 0;

    localparam logic [2:0] S_ACT = 3'b011, S_RD = 3'b101, S_WR = 3'b100,
                           S_PRE = 3'b010, S_REF = 3'b001, S_LMR = 3'b000;

    always #5 clk = ~clk;

    ddr2_cmd_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o), .err_o(err_o),
        .bank_open_o(bank_open_o), .open_rows_o(open_rows_o), .mode_regs_o(mode_regs_o)
    );

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one command at a falling edge; return just after the next rising edge
    task automatic drive(input logic cs, input logic [2:0] strobes,
                         input logic [2:0] b, input logic [13:0] a);
        @(negedge clk);
        cs_n = cs; {ras_n, cas_n, we_n} = strobes; ba = b; addr = a;
        @(posedge clk);
        #1;
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
    endtask

    task automatic issue(input logic [2:0] strobes, input logic [2:0] b, input logic [13:0] a);
        drive(1'b0, strobes, b, a);
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [13:0] row_of(input int b);
        return open_rows_o[b*14 +: 14];
    endfunction

    function automatic logic [13:0] mr_of(input int k);
        return mode_regs_o[k*14 +: 14];
    endfunction

    task automatic t_reset();
        repeat (2) @(posedge clk);
        #1;
        check("R10", "cmd in reset", cmd_o, 3'd0);
        check("R10", "err in reset", err_o, 1'b0);
        check("R10", "banks in reset", bank_open_o, 8'h00);
        check("R10", "rows in reset", open_rows_o, '0);
        check("R10", "mode in reset", mode_regs_o, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_decode();
        issue(S_ACT, 3'd0, 14'h15); check("R1", "activate code", cmd_o, 3'd1);
        issue(S_RD, 3'd0, 14'h0);   check("R1", "read code", cmd_o, 3'd2);
        issue(S_WR, 3'd0, 14'h0);   check("R1", "write code", cmd_o, 3'd3);
        issue(S_PRE, 3'd0, 14'h0);  check("R1", "precharge code", cmd_o, 3'd4);
        issue(S_REF, 3'd0, 14'h0);  check("R1", "refresh code", cmd_o, 3'd5);
        check("R1", "refresh legal when closed", err_o, 1'b0);
        drive(1'b1, S_LMR, 3'd2, 14'h3333);
        check("R1", "deselected code", cmd_o, 3'd0);
        check("R1", "deselected mode untouched", mode_regs_o, '0);
        issue(S_LMR, 3'd2, 14'h55); check("R1", "mode load code", cmd_o, 3'd6);
        idle();                     check("R1", "idle code", cmd_o, 3'd0);
    endtask

    task automatic t_activate();
        issue(S_ACT, 3'd3, 14'h1ABC);
        check("R2", "open flags", bank_open_o, 8'h08);
        check("R2", "row of bank 3", row_of(3), 14'h1ABC);
        check("R2", "no error", err_o, 1'b0);
    endtask

    task automatic t_col_closed();
        issue(S_RD, 3'd5, 14'h0);
        check("R3", "read closed err", err_o, 1'b1);
        check("R3", "flags unchanged", bank_open_o, 8'h08);
        idle();
        check("R3", "err one cycle", err_o, 1'b0);
        issue(S_WR, 3'd6, 14'h400);
        check("R3", "write closed err", err_o, 1'b1);
        check("R3", "flags unchanged after write", bank_open_o, 8'h08);
    endtask

    task automatic t_act_twice();
        issue(S_ACT, 3'd3, 14'h0123);
        check("R4", "double activate err", err_o, 1'b1);
        check("R4", "row kept", row_of(3), 14'h1ABC);
    endtask

    task automatic t_pre_single();
        issue(S_ACT, 3'd1, 14'h7);
        check("R5", "two banks open", bank_open_o, 8'h0A);
        issue(S_PRE, 3'd3, 14'h0);
        check("R5", "only bank 3 closed", bank_open_o, 8'h02);
    endtask

    task automatic t_pre_all();
        issue(S_ACT, 3'd7, 14'h9);
        check("R6", "banks 1 and 7 open", bank_open_o, 8'h82);
        issue(S_PRE, 3'd0, 14'h400);
        check("R6", "all closed", bank_open_o, 8'h00);
    endtask

    task automatic t_load_mode();
        issue(S_LMR, 3'd1, 14'h0044);
        issue(S_LMR, 3'd3, 14'h3FFF);
        issue(S_LMR, 3'd0, 14'h0002);
        check("R7", "mode reg 1", mr_of(1), 14'h0044);
        check("R7", "mode reg 3", mr_of(3), 14'h3FFF);
        check("R7", "mode reg 0", mr_of(0), 14'h0002);
        check("R7", "mode reg 2 kept", mr_of(2), 14'h0055);
    endtask

    task automatic t_ref_lmr_open();
        issue(S_ACT, 3'd2, 14'h2);
        issue(S_REF, 3'd0, 14'h0);
        check("R8", "refresh while open err", err_o, 1'b1);
        issue(S_LMR, 3'd2, 14'h1111);
        check("R8", "mode load while open err", err_o, 1'b1);
        check("R8", "mode reg 2 unchanged", mr_of(2), 14'h0055);
        issue(S_PRE, 3'd0, 14'h400);
    endtask

    task automatic t_autopre(input logic [13:0] mr0, input int edges);
        issue(S_LMR, 3'd0, mr0);
        issue(S_ACT, 3'd4, 14'h44);
        issue(S_RD, 3'd4, 14'h400);
        check("R9", "open at command", bank_open_o[4], 1'b1);
        for (int i = 1; i < edges; i++) begin
            idle();
            check("R9", "open during burst", bank_open_o[4], 1'b1);
        end
        idle();
        check("R9", "closed after burst", bank_open_o[4], 1'b0);
        check("R9", "no error", err_o, 1'b0);
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_decode();
        t_activate();
        t_col_closed();
        t_act_twice();
        t_pre_single();
        t_pre_all();
        t_load_mode();
        t_ref_lmr_open();
        t_autopre(14'h0002, 2);
        t_autopre(14'h0003, 4);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule